// File: doc/BRIEF.md
# Serial Key Unlock Controller

This block decides whether a debug host may see the contents of protected memory. After a power-on reset it waits a fixed settling time and then opens a receive window. The host sends a key one byte at a time over a single-wire half-duplex serial line. A separate bit engine, outside this block, turns the line into byte-valid and byte-send handshakes.

Each accepted byte is echoed back after two bit times. It is also compared with the stored key byte at the matching position. The key is read from eight consecutive protected locations, starting at a base address. After the eighth byte the block sets its unlocked flag only if every byte matched. It then drives a break on the line to tell the host that commands may follow. The break is sent whether or not the key matched.

The unlocked flag survives every reset except power-on. While the block is locked, protected reads return zero, and an instruction fetch from protected memory raises a one-cycle illegal-address reset request. A reset that is not power-on does not ask for the key again once an entry has completed.

Top module: `key_unlock_ctrl`

## Requirements
- R1: After a power-on reset, `rx_open` goes high exactly ENTRY_CYC clock edges after reset release (default 4128).
- R2: Each byte accepted while `rx_open` is high is echoed on `tx_byte` with a one-cycle `tx_send`, ECHO_BITS*BIT_CYC edges after the accepting edge (default 32).
- R3: A byte offered while `rx_open` is low is ignored. This covers the settling wait, the echo delay, the break and the ready state. Such a byte causes no echo and does not advance the key position.
- R4: While waiting for byte i (i = 0..7, counted from the start of entry), `key_addr` equals KEY_BASE + i (default base 16'hFFF6).
- R5: The unlocked flag is set after the eighth byte only if all eight received bytes equal the stored key bytes at their positions. One mismatch at any position leaves the block locked. An erased key (all 8'hFF) is matched by eight 8'hFF bytes.
- R6: `brk_drive` is high for exactly BRK_BITS*BIT_CYC cycles (default 160). It starts on the edge after the eighth echo, whether or not the key matched, and `rdy` is high once it ends.
- R7: `status` carries the unlocked flag in bit 6; all other bits are 0.
- R8: After a reset that is not power-on, once an entry has completed, `rdy` is high after one edge. No window opens and no break is sent, so received bytes are ignored, and the unlocked flag keeps its value.
- R9: Only `por_n` low clears the unlocked flag. Once set, it stays set through any number of `rst_n` resets.
- R10: `rd_data_o` is 8'h00 while `rd_prot` is high and the block is locked. Otherwise it follows `rd_data_i` in the same cycle.
- R11: A cycle with `fetch_valid` and `fetch_prot` both high while locked makes `illegal_req` high for the next cycle only. No pulse is raised when unlocked or when `fetch_prot` is low.
- R12: A reset that is not power-on during an unfinished entry restarts it. The window reopens after ENTRY_CYC edges from byte position 0, and the earlier bytes are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the unlocked flag |
| rst_n | input | 1 | Any other reset, active low; keeps the unlocked flag |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_send | output | 1 | One-cycle request to transmit `tx_byte` |
| tx_byte | output | 8 | Byte to echo |
| brk_drive | output | 1 | Hold the serial line low (break) |
| key_addr | output | 16 | Address of the stored key byte being compared |
| key_data | input | 8 | Stored key byte at `key_addr` |
| rd_prot | input | 1 | Current read targets protected memory |
| rd_data_i | input | 8 | Read data from memory |
| rd_data_o | output | 8 | Read data after gating |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_prot | input | 1 | Fetch targets protected memory |
| illegal_req | output | 1 | Illegal-address reset request pulse |
| status | output | 8 | Status byte, bit 6 = unlocked |
| rx_open | output | 1 | Key receive window open |
| rdy | output | 1 | Entry finished, ready for commands |

## Verification
The eighth echo and the flag update happen on the same edge. So the last echo cycle is also the last cycle in which gating still acts on the old locked state. The bench raises a protected read and a protected fetch in exactly the cycle in which the eighth `tx_send` is seen. It expects the read to be masked and the fetch to be flagged in that cycle. On the following cycle the read must pass through only if the key matched. A further byte offered during the echo delay shows that acceptance and echo never overlap.

// File: rtl/kuc_pkg.sv
package kuc_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_RECV,
    ST_ECHO,
    ST_BREAK,
    ST_READY
  } seq_st_t;

  localparam int unsigned STATUS_UNLOCK_BIT = 6;

  // Cycles covered by a number of bit periods.
  function automatic int unsigned span_cycles(int unsigned bit_cyc, int unsigned bits);
    return bit_cyc * bits;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Status image: unlock flag placed at its fixed bit, rest zero.
  function automatic logic [7:0] status_image(logic unlocked);
    logic [7:0] s;
    s = '0;
    s[STATUS_UNLOCK_BIT] = unlocked;
    return s;
  endfunction

endpackage

// File: rtl/kuc_timer.sv
module kuc_timer #(
  parameter int unsigned CNT_W = 13
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt != {CNT_W{1'b1}}) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/kuc_seq.sv
module kuc_seq import kuc_pkg::*; #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned KEY_LEN   = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFFF6,
  parameter int unsigned ENTRY_CYC = 4128,
  parameter int unsigned ECHO_CYC  = 32,
  parameter int unsigned BRK_CYC   = 160,
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned IDX_W     = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              need_entry,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] key_data,
  output logic [ADDR_W-1:0] key_addr,
  output logic              tx_send,
  output logic [DATA_W-1:0] tx_byte,
  output logic              brk_drive,
  output logic              rdy,
  output logic              rx_open,
  output logic              rx_accept,
  output logic              entry_done,
  output logic              match_ok,
  output logic              entry_finish,
  output logic [IDX_W-1:0]  idx
);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             hit;
  logic             last_byte;
  logic [IDX_W-1:0] idx_q;
  logic             match_q;
  logic [DATA_W-1:0] echo_q;

  always_comb begin
    unique case (st_q)
      ST_WAIT:  lim = CNT_W'(ENTRY_CYC - 1);
      ST_ECHO:  lim = CNT_W'(ECHO_CYC - 1);
      ST_BREAK: lim = CNT_W'(BRK_CYC - 1);
      default:  lim = '0;
    endcase
  end

  assign hit       = (cnt == lim);
  assign last_byte = (idx_q == IDX_W'(KEY_LEN));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT: begin
        if (!need_entry)  st_d = ST_READY;
        else if (hit)     st_d = ST_RECV;
      end
      ST_RECV:  if (rx_valid) st_d = ST_ECHO;
      ST_ECHO:  if (hit) st_d = last_byte ? ST_BREAK : ST_RECV;
      ST_BREAK: if (hit) st_d = ST_READY;
      default:  st_d = st_q;
    endcase
  end

  kuc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_d != st_q),
    .cnt   (cnt)
  );

  assign rx_accept = (st_q == ST_RECV) && rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_WAIT;
      idx_q   <= '0;
      match_q <= 1'b1;
      echo_q  <= '0;
    end else begin
      st_q <= st_d;
      if (rx_accept) begin
        idx_q   <= idx_q + IDX_W'(1);
        match_q <= match_q & (rx_byte == key_data);
        echo_q  <= rx_byte;
      end
    end
  end

  assign key_addr     = KEY_BASE + ADDR_W'(idx_q);
  assign tx_send      = (st_q == ST_ECHO) && hit;
  assign tx_byte      = echo_q;
  assign brk_drive    = (st_q == ST_BREAK);
  assign rdy          = (st_q == ST_READY);
  assign rx_open      = (st_q == ST_RECV);
  assign entry_done   = tx_send && last_byte;
  assign match_ok     = match_q;
  assign entry_finish = (st_q == ST_BREAK) && hit;
  assign idx          = idx_q;

endmodule

// File: rtl/kuc_lock.sv
module kuc_lock (
  input  logic clk,
  input  logic por_n,
  input  logic entry_done,
  input  logic match_ok,
  input  logic entry_finish,
  output logic unlocked,
  output logic need_entry
);

  // Only the power-on reset touches this state.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      unlocked   <= 1'b0;
      need_entry <= 1'b1;
    end else begin
      if (entry_done && match_ok) unlocked <= 1'b1;
      if (entry_finish)           need_entry <= 1'b0;
    end
  end

endmodule

// File: rtl/kuc_gate.sv
module kuc_gate import kuc_pkg::*; #(
  parameter int unsigned DATA_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlocked,
  input  logic              rd_prot,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              fetch_valid,
  input  logic              fetch_prot,
  output logic              illegal_req,
  output logic [7:0]        status
);

  logic blocked_rd;
  logic blocked_fetch;

  assign blocked_rd    = rd_prot && !unlocked;
  assign blocked_fetch = fetch_valid && fetch_prot && !unlocked;
  assign rd_data_o     = blocked_rd ? '0 : rd_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_req <= 1'b0;
    else        illegal_req <= blocked_fetch;
  end

  assign status = status_image(unlocked);

endmodule

// File: rtl/key_unlock_ctrl.sv
module key_unlock_ctrl import kuc_pkg::*; #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned KEY_LEN   = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] KEY_BASE = 16'hFFF6,
  parameter int unsigned BIT_CYC   = 16,
  parameter int unsigned ECHO_BITS = 2,
  parameter int unsigned BRK_BITS  = 10,
  parameter int unsigned ENTRY_CYC = 4128
)(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              tx_send,
  output logic [DATA_W-1:0] tx_byte,
  output logic              brk_drive,
  output logic [ADDR_W-1:0] key_addr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              rd_prot,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              fetch_valid,
  input  logic              fetch_prot,
  output logic              illegal_req,
  output logic [7:0]        status,
  output logic              rx_open,
  output logic              rdy
);

  localparam int unsigned ECHO_CYC = span_cycles(BIT_CYC, ECHO_BITS);
  localparam int unsigned BRK_CYC  = span_cycles(BIT_CYC, BRK_BITS);
  localparam int unsigned CNT_W    = $clog2(max3(ENTRY_CYC, ECHO_CYC, BRK_CYC) + 1);
  localparam int unsigned IDX_W    = $clog2(KEY_LEN + 1);

  logic             sys_rst_n;
  logic             unlocked;
  logic             need_entry;
  logic             rx_accept;
  logic             entry_done;
  logic             match_ok;
  logic             entry_finish;
  logic [IDX_W-1:0] idx;

  assign sys_rst_n = rst_n & por_n;

  kuc_seq #(
    .DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .ADDR_W(ADDR_W), .KEY_BASE(KEY_BASE),
    .ENTRY_CYC(ENTRY_CYC), .ECHO_CYC(ECHO_CYC), .BRK_CYC(BRK_CYC),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (sys_rst_n),
    .need_entry   (need_entry),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .key_data     (key_data),
    .key_addr     (key_addr),
    .tx_send      (tx_send),
    .tx_byte      (tx_byte),
    .brk_drive    (brk_drive),
    .rdy          (rdy),
    .rx_open      (rx_open),
    .rx_accept    (rx_accept),
    .entry_done   (entry_done),
    .match_ok     (match_ok),
    .entry_finish (entry_finish),
    .idx          (idx)
  );

  kuc_lock u_lock (
    .clk          (clk),
    .por_n        (por_n),
    .entry_done   (entry_done),
    .match_ok     (match_ok),
    .entry_finish (entry_finish),
    .unlocked     (unlocked),
    .need_entry   (need_entry)
  );

  kuc_gate #(.DATA_W(DATA_W)) u_gate (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .unlocked    (unlocked),
    .rd_prot     (rd_prot),
    .rd_data_i   (rd_data_i),
    .rd_data_o   (rd_data_o),
    .fetch_valid (fetch_valid),
    .fetch_prot  (fetch_prot),
    .illegal_req (illegal_req),
    .status      (status)
  );

endmodule

// File: rtl/kuc_checker.sv
module kuc_checker #(
  parameter int unsigned ENTRY_CYC = 4128,
  parameter int unsigned ECHO_CYC  = 32,
  parameter int unsigned BRK_CYC   = 160,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned DATA_W    = 8
)(
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              rx_open,
  input logic              rx_accept,
  input logic              tx_send,
  input logic              brk_drive,
  input logic              rdy,
  input logic              unlocked,
  input logic              need_entry,
  input logic              entry_done,
  input logic              match_ok,
  input logic              rd_prot,
  input logic              fetch_valid,
  input logic              fetch_prot,
  input logic              illegal_req,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [IDX_W-1:0]  idx
);

  int unsigned since_rst;
  int unsigned ecnt;
  int unsigned bcnt;
  logic        pend;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      since_rst <= 0;
      ecnt      <= 0;
      bcnt      <= 0;
      pend      <= 1'b0;
    end else begin
      if (since_rst <= ENTRY_CYC) since_rst <= since_rst + 1;
      if (rx_accept) begin
        pend <= 1'b1;
        ecnt <= 0;
      end else if (tx_send) begin
        pend <= 1'b0;
      end else if (pend) begin
        ecnt <= ecnt + 1;
      end
      bcnt <= brk_drive ? bcnt + 1 : 0;
    end
  end

  assert_window_R1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    ($rose(rx_open) && idx == '0) |-> since_rst == ENTRY_CYC);

  assert_echo_delay_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    tx_send |-> (pend && ecnt == ECHO_CYC - 1));

  assert_echo_single_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    tx_send |=> !tx_send);

  assert_no_stray_echo_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pend == 1'b0) |-> !tx_send);

  assert_unlock_cause_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(unlocked) |-> $past(entry_done && match_ok));

  assert_break_len_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    brk_drive |-> bcnt < BRK_CYC);

  assert_break_end_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(brk_drive) |-> rdy);

  assert_skip_entry_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !need_entry |-> (!rx_open && !brk_drive));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    unlocked |=> unlocked);

  assert_read_mask_R10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (rd_prot && !unlocked) |-> rd_data_o == '0);

  assert_fetch_flag_R11: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (fetch_valid && fetch_prot && !unlocked) |=> illegal_req);

  assert_fetch_cause_R11: assert property (@(posedge clk) disable iff (!sys_rst_n)
    illegal_req |-> $past(fetch_valid && fetch_prot && !unlocked));

endmodule

bind key_unlock_ctrl kuc_checker #(
  .ENTRY_CYC(ENTRY_CYC), .ECHO_CYC(ECHO_CYC), .BRK_CYC(BRK_CYC),
  .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .sys_rst_n   (sys_rst_n),
  .rx_open     (rx_open),
  .rx_accept   (rx_accept),
  .tx_send     (tx_send),
  .brk_drive   (brk_drive),
  .rdy         (rdy),
  .unlocked    (unlocked),
  .need_entry  (need_entry),
  .entry_done  (entry_done),
  .match_ok    (match_ok),
  .rd_prot     (rd_prot),
  .fetch_valid (fetch_valid),
  .fetch_prot  (fetch_prot),
  .illegal_req (illegal_req),
  .rd_data_o   (rd_data_o),
  .idx         (idx)
);

// File: tb/key_unlock_ctrl_test.sv
module key_unlock_ctrl_test;

  localparam int unsigned BIT_CYC   = 16;
  localparam int unsigned ENTRY_CYC = 4128;
  localparam int unsigned ECHO_CYC  = 2 * BIT_CYC;
  localparam int unsigned BRK_CYC   = 10 * BIT_CYC;
  localparam logic [15:0] BASE      = 16'hFFF6;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        tx_send;
  logic [7:0]  tx_byte;
  logic        brk_drive;
  logic [15:0] key_addr;
  logic [7:0]  key_data;
  logic        rd_prot = 1'b0;
  logic [7:0]  rd_data_i = 8'h00;
  logic [7:0]  rd_data_o;
  logic        fetch_valid = 1'b0;
  logic        fetch_prot = 1'b0;
  logic        illegal_req;
  logic [7:0]  status;
  logic        rx_open;
  logic        rdy;

  logic [7:0]  kmem [8];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          rel = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    logic [15:0] off;
    off = key_addr - BASE;
    key_data = (off < 16'd8) ? kmem[off[2:0]] : 8'h00;
  end

  key_unlock_ctrl #(
    .DATA_W(8), .KEY_LEN(8), .ADDR_W(16), .KEY_BASE(16'hFFF6),
    .BIT_CYC(BIT_CYC), .ECHO_BITS(2), .BRK_BITS(10), .ENTRY_CYC(ENTRY_CYC)
  ) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_send(tx_send), .tx_byte(tx_byte), .brk_drive(brk_drive), .key_addr(key_addr),
    .key_data(key_data), .rd_prot(rd_prot), .rd_data_i(rd_data_i), .rd_data_o(rd_data_o),
    .fetch_valid(fetch_valid), .fetch_prot(fetch_prot), .illegal_req(illegal_req),
    .status(status), .rx_open(rx_open), .rdy(rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] exp_status(input bit ok);
    return ok ? 8'h40 : 8'h00;
  endfunction

  function automatic bit key_equal(input logic [63:0] a, input logic [63:0] b);
    for (int i = 0; i < 8; i++) if (a[i*8 +: 8] != b[i*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R9 unlock clear in POR", status, 8'h00);
    chk("R6 no break in reset", brk_drive, 1'b0);
    chk("R2 no echo in reset", tx_send, 1'b0);
    chk("R11 no flag in reset", illegal_req, 1'b0);
    por_n = 1'b1;
    rst_n = 1'b1;
    rel = cyc;
  endtask

  task automatic do_rst();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    rel = cyc;
  endtask

  task automatic wait_open(output int n);
    int guard = 0;
    while (!rx_open && guard < 20000) begin
      tick();
      guard++;
    end
    n = cyc - rel;
  endtask

  task automatic stray_byte(input string tag);
    bit seen = 1'b0;
    rx_valid = 1'b1;
    rx_byte  = 8'h3C;
    tick();
    rx_valid = 1'b0;
    for (int k = 0; k < ECHO_CYC + 4; k++) begin
      if (tx_send || brk_drive) seen = 1'b1;
      tick();
    end
    chk(tag, seen, 1'b0);
  endtask

  task automatic send_byte(input logic [7:0] b, input int i, input bit inject,
                           input bit probe, input bit exp_ok);
    int n;
    int guard = 0;
    while (!rx_open && guard < 1000) begin
      tick();
      guard++;
    end
    chk("R4 key address", key_addr, BASE + 16'(i));
    rx_valid = 1'b1;
    rx_byte  = b;
    tick();
    rx_valid = 1'b0;
    n = 1;
    if (inject) begin
      // R3: byte during echo delay must be ignored
      rx_valid = 1'b1;
      rx_byte  = ~b;
      tick();
      rx_valid = 1'b0;
      n++;
    end
    while (!tx_send && n < 1000) begin
      tick();
      n++;
    end
    chk("R2 echo delay", n, ECHO_CYC);
    chk(inject ? "R3 echo byte after stray" : "R2 echo byte", tx_byte, b);
    if (probe) begin
      rd_prot = 1'b1;
      rd_data_i = 8'hA5;
      fetch_valid = 1'b1;
      fetch_prot = 1'b1;
      #1;
      chk("R10 read masked in last echo cycle", rd_data_o, 8'h00);
      tick();
      fetch_valid = 1'b0;
      fetch_prot = 1'b0;
      #1;
      chk("R11 fetch flagged in last echo cycle", illegal_req, 1'b1);
      chk("R10 read after flag update", rd_data_o, exp_ok ? 8'hA5 : 8'h00);
      rd_prot = 1'b0;
    end
  endtask

  task automatic session(input logic [63:0] keyv, input logic [63:0] sentv,
                         input bit probe, input int abort_after);
    int n;
    bit ok;
    ok = key_equal(keyv, sentv);
    for (int i = 0; i < 8; i++) kmem[i] = keyv[i*8 +: 8];
    do_por();
    stray_byte("R3 byte during settling wait");
    wait_open(n);
    chk("R1 window opens after settling", n, ENTRY_CYC);
    if (abort_after > 0) begin
      for (int i = 0; i < abort_after; i++) begin
        send_byte(sentv[i*8 +: 8], i, 1'b0, 1'b0, ok);
        repeat (BIT_CYC) tick();
      end
      do_rst();
      wait_open(n);
      chk("R12 window reopens after plain reset", n, ENTRY_CYC);
    end
    for (int i = 0; i < 8; i++) begin
      send_byte(sentv[i*8 +: 8], i, (i == 2), probe && (i == 7), ok);
      if (i < 7) repeat (BIT_CYC) tick();
    end
    if (!probe) tick();
    n = 0;
    while (brk_drive && n < 1000) begin
      n++;
      tick();
    end
    chk("R6 break length", n, BRK_CYC);
    chk("R6 ready after break", rdy, 1'b1);
    chk("R5 unlock result", status[6], ok);
    chk("R7 status byte", status, exp_status(ok));
    stray_byte("R3 byte in ready state");
    fetch_valid = 1'b1;
    fetch_prot = 1'b1;
    tick();
    fetch_valid = 1'b0;
    fetch_prot = 1'b0;
    chk("R11 protected fetch after entry", illegal_req, !ok);
    tick();
    chk("R11 pulse lasts one cycle", illegal_req, 1'b0);
    fetch_valid = 1'b1;
    tick();
    fetch_valid = 1'b0;
    chk("R11 unprotected fetch", illegal_req, 1'b0);
    rd_data_i = 8'h5E;
    rd_prot = 1'b1;
    #1;
    chk("R10 protected read", rd_data_o, ok ? 8'h5E : 8'h00);
    rd_prot = 1'b0;
    #1;
    chk("R10 unprotected read", rd_data_o, 8'h5E);
  endtask

  task automatic plain_reset_check(input bit exp_ok);
    bit seen = 1'b0;
    do_rst();
    tick();
    chk("R8 ready one edge after plain reset", rdy, 1'b1);
    chk("R9 unlock kept over plain reset", status, exp_status(exp_ok));
    for (int k = 0; k < 64; k++) begin
      if (rx_open || brk_drive) seen = 1'b1;
      tick();
    end
    chk("R8 no window and no break", seen, 1'b0);
    stray_byte("R8 bytes ignored after plain reset");
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] k;
    logic [63:0] s;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) kmem[i] = 8'h00;
    @(negedge clk);
    chk("R7 status in reset", status, 8'h00);
    chk("R1 window closed in reset", rx_open, 1'b0);

    // Correct key with the same-cycle probe, then plain resets.
    k = 64'h8877_6655_4433_2211;
    session(k, k, 1'b1, 0);
    plain_reset_check(1'b1);
    plain_reset_check(1'b1);

    // Wrong last byte: locked, break still sent, then plain reset keeps it locked.
    s = k ^ 64'h0100_0000_0000_0000;
    session(k, s, 1'b1, 0);
    plain_reset_check(1'b0);

    // Mismatch in the first byte only.
    session(k, k ^ 64'h0000_0000_0000_0080, 1'b0, 0);

    // Entry cut by a plain reset after three bytes, then a full correct key.
    k = 64'hC3D2_E1F0_0F1E_2D3C;
    session(k, k, 1'b0, 3);

    // Erased key region matched by all-ones bytes.
    session(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0);

    // Random keys, some with a single corrupted byte.
    for (int r = 0; r < 3; r++) begin
      k = {$urandom, $urandom};
      s = k;
      if (($urandom % 2) == 0) begin
        int pos;
        logic [7:0] x;
        pos = $urandom % 8;
        x = 8'($urandom % 255) + 8'd1;
        s[pos*8 +: 8] = s[pos*8 +: 8] ^ x;
      end
      session(k, s, (r == 1), 0);
    end

    summary();
  end

endmodule